// File: doc/BRIEF.md
# Programmable Square Wave Generator

The block counts a timebase enable through a 15-bit ripple-free divider and picks one divider stage with a 4-bit rate code. That stage drives a square-wave pin and a one-clock periodic event strobe, which an interrupt controller outside the block consumes. The timebase enable pulses twice per period of the 32.768 kHz oscillator, so each pulse is one oscillator half-period. Bit 0 of the divider is therefore the oscillator level itself. Bit k has a period of 2^(k+1) enable pulses.

A 3-bit oscillator control field sets the divider's state. Pattern 01x runs the divider. Pattern 11x clears the divider and holds it at zero. Any other pattern freezes the divider where it is. An output enable gates the pin. A bypass enable puts the undivided oscillator level on the pin, and this applies only when the oscillator control is exactly 011. The bypass does not change the rate of the periodic event. A new rate code takes effect only at an edge of the stage that is currently selected, so the pin never shows a runt pulse.

Top module: `sqwave_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `sq_out` and `per_evt` are 0 and the divider is at zero.
- R2: While the active rate code is 0, the pin is low (apart from bypass) and no event is issued. A new code is taken on the next clock with no wait for a tap edge.
- R3: Code 1 selects divider bit 7 (period 256 enable pulses, 256 Hz). Code 2 selects bit 8 (period 512 pulses, 128 Hz).
- R4: Codes 3 to 15 select divider bit code-1. This gives a period of 2^code enable pulses, from 8.192 kHz at code 3 down to 2 Hz at code 15.
- R5: `per_evt` is high for exactly one clock. This happens in the clock after an enable pulse that moves the selected bit from 0 to 1, so there is one event per period.
- R6: With `sq_en` at 0 the pin is low, and events continue unchanged.
- R7: With `sq_en`=1, `byp_en`=1 and `osc_ctl`=011, the pin follows divider bit 0. It toggles on every enable pulse, and the event rate is unchanged. With any other `osc_ctl` value, `byp_en` has no effect.
- R8: With `osc_ctl`=11x the divider is cleared and held at zero. The pin level is cleared and no event is issued.
- R9: With `osc_ctl`=00x or 10x the divider, the pin level and the events are frozen.
- R10: A change of `rate_sel` is adopted only at the next edge of the active tap (or at once from code 0). The pin changes only in the clock after an enable pulse or after a change of `sq_en`, `byp_en` or `osc_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable, one pulse per oscillator half-period |
| rate_sel | input | 4 | Rate code |
| osc_ctl | input | 3 | Oscillator control: 01x run, 11x clear, other freeze |
| sq_en | input | 1 | Square-wave pin enable |
| byp_en | input | 1 | Raw oscillator bypass enable |
| sq_out | output | 1 | Square-wave pin level |
| per_evt | output | 1 | One-clock periodic event strobe |

## Verification
The functions that collide are a rate-code change and the active tap's own edge. A new code written in the very enable cycle where the old tap rises must still yield the event for the old tap, and the new code is adopted at that same edge. The bench moves `rate_sel` every 37 clocks while the enable runs on every clock, so many changes land on tap edges. It also runs the bypass while events are firing. A behavioural model works out tap levels from an integer count by division and judges pin and strobe on every clock.

// File: rtl/sqwave_gen.sv
module sqwave_gen #(
  parameter int DIV_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic [2:0]        osc_ctl,
  input  logic              sq_en,
  input  logic              byp_en,
  output logic              sq_out,
  output logic              per_evt
);
  localparam int IW = $clog2(DIV_W);

  function automatic logic [IW-1:0] tap_of(input logic [CODE_W-1:0] c);
    case (c)
      CODE_W'(0): tap_of = '0;
      CODE_W'(1): tap_of = IW'(7);
      CODE_W'(2): tap_of = IW'(8);
      default:    tap_of = IW'(c - 1'b1);
    endcase
  endfunction

  logic [DIV_W-1:0]  div_q, div_nx;
  logic [CODE_W-1:0] act_q;
  logic              out_q, pev_q;
  logic [IW-1:0]     idx;
  logic              tap_now, tap_nx;

  wire run  = (osc_ctl[2:1] == 2'b01);
  wire clr  = (osc_ctl[2:1] == 2'b11);
  wire step = tick_en & run;
  wire byp  = byp_en & (osc_ctl == 3'b011);

  assign div_nx  = div_q + 1'b1;
  assign idx     = tap_of(act_q);
  assign tap_now = div_q[idx];
  assign tap_nx  = div_nx[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      act_q <= '0;
      out_q <= 1'b0;
      pev_q <= 1'b0;
    end else begin
      pev_q <= 1'b0;
      if (clr)       div_q <= '0;
      else if (step) div_q <= div_nx;
      if (act_q == '0) begin
        out_q <= 1'b0;
        act_q <= rate_sel;
      end else if (clr) begin
        out_q <= 1'b0;
      end else if (step && (tap_now != tap_nx)) begin
        out_q <= tap_nx & (rate_sel != '0);
        act_q <= rate_sel;
        pev_q <= tap_nx;
      end
    end
  end

  assign sq_out  = sq_en & (byp ? div_q[0] : out_q);
  assign per_evt = pev_q;

  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> $past(tick_en)); // R5
  AST_EVT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> !per_evt); // R5
  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (div_q == '0 && !per_evt)); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(div_q) && !per_evt)); // R9
  AST_PIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_en) && $stable(sq_en) && $stable(byp_en) && $stable(osc_ctl)) |-> $stable(sq_out)); // R10
endmodule

// File: tb/sim_sqwave_gen.sv
module sim_sqwave_gen;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, sq_en = 1'b0, byp_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] osc_ctl = 3'b000;
  logic sq_out, per_evt;
  int total = 0, bad = 0, tick_every = 2, tphase = 0;
  string tag = "R1";
  bit checking = 1'b0;

  always #2.5 clk = ~clk;

  sqwave_gen u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .osc_ctl(osc_ctl), .sq_en(sq_en), .byp_en(byp_en), .sq_out(sq_out), .per_evt(per_evt));

  always @(negedge clk) begin
    tphase <= tphase + 1;
    tick_en <= ((tphase + 1) % tick_every) == 0;
  end

  int m_cnt, m_act, m_out, m_pev;
  function automatic int bit_of(int c);
    if (c == 1) return 7;
    if (c == 2) return 8;
    return c - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_out = 0; m_pev = 0;
    end else begin
      int nxt, o, n, b;
      bit run, clr;
      run = osc_ctl[2:1] == 2'b01;
      clr = osc_ctl[2:1] == 2'b11;
      nxt = (tick_en && run) ? (m_cnt + 1) % 32768 : (clr ? 0 : m_cnt);
      m_pev = 0;
      if (m_act == 0) begin
        m_out = 0; m_act = rate_sel;
      end else if (clr) begin
        m_out = 0;
      end else if (tick_en && run) begin
        b = bit_of(m_act);
        o = (m_cnt / (1 << b)) % 2;
        n = (nxt / (1 << b)) % 2;
        if (o != n) begin
          m_out = (rate_sel != 0) ? n : 0;
          m_act = rate_sel;
          m_pev = n;
        end
      end
      m_cnt = nxt;
    end
  end

  task automatic check(string t, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (checking) begin
      int ep;
      ep = sq_en ? ((byp_en && osc_ctl == 3'b011) ? (m_cnt % 2) : m_out) : 0;
      check(tag, sq_out, ep, "sq_out");
      check(tag, per_evt, m_pev, "per_evt");
    end
  end

  task automatic phase(string t, int rate, logic [2:0] osc, bit en, bit byp, int te, int n);
    @(negedge clk);
    tag = t; rate_sel = 4'(rate); osc_ctl = osc; sq_en = en; byp_en = byp; tick_every = te;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", sq_out, 0, "sq_out in reset");
    check("R1", per_evt, 0, "per_evt in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sq_out, 0, "sq_out after reset");
    check("R1", per_evt, 0, "per_evt after reset");
    checking = 1'b1;
    phase("R2", 0, 3'b010, 1, 0, 2, 400);
    phase("R3", 1, 3'b010, 1, 0, 1, 2600);
    phase("R3", 2, 3'b010, 1, 0, 1, 2600);
    for (int c = 3; c <= 12; c++) phase("R4", c, 3'b010, 1, 0, 1, (1 << (c + 1)) + 120);
    phase("R4", 15, 3'b010, 1, 0, 1, 33000);
    phase("R6", 3, 3'b010, 0, 0, 1, 400);
    phase("R7", 5, 3'b011, 1, 1, 2, 600);
    phase("R7", 5, 3'b010, 1, 1, 2, 300);
    phase("R8", 4, 3'b110, 1, 0, 1, 200);
    phase("R8", 4, 3'b111, 1, 1, 1, 100);
    phase("R9", 4, 3'b010, 1, 0, 1, 300);
    phase("R9", 4, 3'b000, 1, 0, 1, 200);
    phase("R9", 4, 3'b101, 1, 0, 1, 200);
    phase("R2", 0, 3'b010, 1, 0, 1, 100);
    for (int k = 0; k < 40; k++) begin
      int codes[8] = '{4, 9, 3, 0, 6, 3, 8, 5};
      phase("R10", codes[k % 8], (k % 5 == 2) ? 3'b011 : 3'b010, 1, (k % 3 == 0), 1, 37);
    end
    checking = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule